// File: doc/BRIEF.md
# Dual-Format Management Register Slave

This block is the management register slave of a four-lane 10G transceiver. A station manager reaches it over the two-wire MDC/MDIO serial interface, using either the older short-address frame format (Clause 22) or the extended-address format (Clause 45). Both formats land in the same small register file. That file holds writable control words with fixed reset defaults, read-only ability and status words, and a fault word whose fault bits latch high. The writable words are driven straight out as configuration buses for the datapath.

In the extended format the block answers to one device address, which is picked from two strap pins while reset is held and kept once reset is released. Its extended register space has a low window at 0x0000 that carries the same words as the short format's lower half. It also has a vendor window at 0xC000 that carries the short format's upper half. The MDC and MDIO lines are brought into the system clock domain, so MDC must run well below the system clock.

Top module: `mgmt_serial_regs`

## Requirements
- R1: After reset the writable words hold these values, on their cfg ports and when read back: control (short address 0x00) = 0x2040, misc1 (0x10) = 0x00C0, misc2 (0x11) = 0x0140, error code (0x16) = 0x00FF, receive clock (0x18) = 0x0001, symbol (0x19) = 0x000F, idle code (0x1B) = 0x0007, test (0x1E) = 0xAAAA, half rate (0x1F) = 0x0000.
- R2: A short-format frame is at least 32 preamble ones, then start bits 0,1, then op (10 read, 01 write), then a 5-bit port address, a 5-bit register address, 2 turnaround bits and 16 data bits, all MSB first. The port address must equal PORT_ADDR (default 0). A write updates the addressed writable word. Frames for another port address change nothing.
- R3: On a read that is answered, mdio_oe is high for exactly the 16 data bit periods and low at all other times, with the data shifted out MSB first. Frames that are not answered never raise mdio_oe.
- R4: Read-only words: status (0x01) = {1, eleven zeros, lane_ok[3:0]}, speed ability (0x04) = 0x0001, devices (0x05) = 0x0021. Writes to these words have no effect.
- R5: Reads of unimplemented addresses return 0x0000, with a normal 16-bit drive. Writes to them are ignored.
- R6: Fault word (0x08): bit 15 reads 1, bit 11 is the latched transmit fault and bit 10 is the latched receive fault. A latched bit is set while its source is high. It stays set after the source drops and clears on a read of the word, unless the source is still high. The read returns the latched value.
- R7: The device address is taken from strap[1:0] while reset is low and held after release: 11 gives 5, 10 gives 4, 01 gives 30, 00 gives 31. Strap changes after reset have no effect.
- R8: An extended frame has start bits 0,0, then op 00 (set address), 01 (write), 11 (read) or 10 (read then increment), then a 5-bit port address that must equal PORT_ADDR, then a 5-bit device address that must equal the strapped one, then the turnaround bits and the 16 data bits. A frame with any other device address is not answered and changes nothing.
- R9: Extended addresses 0x0000–0x000F reach the same words as short addresses 0x00–0x0F, and 0xC000–0xC00F reach short addresses 0x10–0x1F. All other extended addresses are unimplemented. The fault word reads alike under every device address.
- R10: An extended read-then-increment frame adds one to the held address after the read. A plain read leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 2 | Device address strap pins |
| mdc | input | 1 | Management clock |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Data out enable |
| lane_ok | input | 4 | Per-lane status into the status word |
| tx_fault | input | 1 | Transmit fault source |
| rx_fault | input | 1 | Receive fault source |
| cfg_control | output | 16 | Control word |
| cfg_misc1 | output | 16 | Misc control 1 |
| cfg_misc2 | output | 16 | Misc control 2 |
| cfg_err_code | output | 16 | Error code word |
| cfg_rx_clk | output | 16 | Receive clock mode |
| cfg_symbol | output | 16 | Symbol control |
| cfg_idle | output | 16 | Idle code |
| cfg_test | output | 16 | Test word |
| cfg_half_rate | output | 16 | Half-rate enables |

## Verification
The hardest state to reach from the ports is a device address other than the pull-up default, together with proof that a later strap change does not move it. The stimulus resets the block once for each strap pattern and then flips the straps to a different value. Next it sends an address frame and a read frame under all four candidate device addresses, and expects exactly one of them to be answered. The read-clear of the latched fault bits is reached by reading the fault word while a source is still high, dropping that source, and reading twice more.

// File: rtl/mgmt_serial_regs.sv
module mgmt_serial_regs #(
  parameter int PORT_ADDR = 0,
  parameter int PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic [3:0]  lane_ok,
  input  logic        tx_fault,
  input  logic        rx_fault,
  output logic [15:0] cfg_control,
  output logic [15:0] cfg_misc1,
  output logic [15:0] cfg_misc2,
  output logic [15:0] cfg_err_code,
  output logic [15:0] cfg_rx_clk,
  output logic [15:0] cfg_symbol,
  output logic [15:0] cfg_idle,
  output logic [15:0] cfg_test,
  output logic [15:0] cfg_half_rate
);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [31:0] WR_MASK = 32'hCB43_0001;

  function automatic logic [15:0] dflt(input logic [4:0] i);
    case (i)
      5'h00: dflt = 16'h2040;
      5'h10: dflt = 16'h00C0;
      5'h11: dflt = 16'h0140;
      5'h16: dflt = 16'h00FF;
      5'h18: dflt = 16'h0001;
      5'h19: dflt = 16'h000F;
      5'h1B: dflt = 16'h0007;
      5'h1E: dflt = 16'hAAAA;
      default: dflt = 16'h0000;
    endcase
  endfunction

  logic [2:0]  mdc_q;
  logic [1:0]  dio_q;
  logic [4:0]  devad;
  logic        busy, oe_r, mo;
  logic [4:0]  cnt;
  logic [PW-1:0] ones;
  logic [14:0] sh, od;
  logic        c45_q, rd_q, hit_q, impl_q;
  logic [1:0]  op_q;
  logic [4:0]  idx_q;
  logic [15:0] addr45;
  logic        lh_tx, lh_rx;
  logic [15:0] rf [32];
  logic [15:0] rv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= '0;
      dio_q <= 2'b11;
    end else begin
      mdc_q <= {mdc_q[1:0], mdc};
      dio_q <= {dio_q[0], mdio_i};
    end
  end

  wire rise   = mdc_q[1] & ~mdc_q[2];
  wire bit_in = dio_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n)
      case (strap)
        2'b11:   devad <= 5'd5;
        2'b10:   devad <= 5'd4;
        2'b01:   devad <= 5'd30;
        default: devad <= 5'd31;
      endcase
  end

  wire [12:0] hdr   = {sh[11:0], bit_in};
  wire        st1   = hdr[12];
  wire [1:0]  op    = hdr[11:10];
  wire [4:0]  pa    = hdr[9:5];
  wire [4:0]  ra    = hdr[4:0];
  wire        hit   = (pa == PORT_ADDR[4:0]) && (st1 || ra == devad);
  wire        impl45 = (addr45[15:4] == 12'h000) || (addr45[15:4] == 12'hC00);
  wire [4:0]  idx45 = {addr45[15], addr45[3:0]};
  wire [15:0] wdata = {sh, bit_in};

  wire last   = rise && busy && cnt == 5'd31;
  wire rd_go  = rise && busy && cnt == 5'd15 && hit_q && rd_q;
  wire wr_rf  = last && hit_q && impl_q && op_q == 2'b01;
  wire set_a  = last && hit_q && c45_q && op_q == 2'b00;
  wire inc_go = rd_go && c45_q && op_q == 2'b10;
  wire clr8   = rd_go && impl_q && idx_q == 5'd8;

  always_comb begin
    case (idx_q)
      5'd1:    rv = {1'b1, 11'b0, lane_ok};
      5'd4:    rv = 16'h0001;
      5'd5:    rv = 16'h0021;
      5'd8:    rv = {1'b1, 3'b0, lh_tx, lh_rx, 10'b0};
      default: rv = WR_MASK[idx_q] ? rf[idx_q] : 16'h0000;
    endcase
    if (!impl_q) rv = 16'h0000;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; ones <= '0; sh <= '0; od <= '0;
      mo <= 1'b0; oe_r <= 1'b0; c45_q <= 1'b0; rd_q <= 1'b0;
      hit_q <= 1'b0; impl_q <= 1'b0; op_q <= '0; idx_q <= '0;
      addr45 <= '0;
    end else if (rise) begin
      sh <= {sh[13:0], bit_in};
      if (!busy) begin
        if (bit_in) begin
          if (ones != PW'(PRE_LEN)) ones <= ones + 1'b1;
        end else begin
          if (ones == PW'(PRE_LEN)) begin
            busy <= 1'b1;
            cnt  <= 5'd1;
          end
          ones <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == 5'd13) begin
          c45_q  <= ~st1;
          op_q   <= op;
          rd_q   <= st1 ? (op == 2'b10) : op[1];
          hit_q  <= hit;
          idx_q  <= st1 ? ra : idx45;
          impl_q <= st1 | impl45;
        end
        if (rd_go) begin
          mo   <= rv[15];
          od   <= rv[14:0];
          oe_r <= 1'b1;
          if (inc_go) addr45 <= addr45 + 1'b1;
        end else if (oe_r) begin
          mo <= od[14];
          od <= {od[13:0], 1'b0};
        end
        if (cnt == 5'd31) begin
          busy <= 1'b0;
          oe_r <= 1'b0;
          cnt  <= '0;
          if (set_a) addr45 <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) rf[k] <= dflt(5'(k));
    end else if (wr_rf && WR_MASK[idx_q]) begin
      rf[idx_q] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lh_tx <= 1'b0;
      lh_rx <= 1'b0;
    end else begin
      lh_tx <= tx_fault | (lh_tx & ~clr8);
      lh_rx <= rx_fault | (lh_rx & ~clr8);
    end
  end

  assign mdio_o  = oe_r & mo;
  assign mdio_oe = oe_r;

  assign cfg_control   = rf[5'h00];
  assign cfg_misc1     = rf[5'h10];
  assign cfg_misc2     = rf[5'h11];
  assign cfg_err_code  = rf[5'h16];
  assign cfg_rx_clk    = rf[5'h18];
  assign cfg_symbol    = rf[5'h19];
  assign cfg_idle      = rf[5'h1B];
  assign cfg_test      = rf[5'h1E];
  assign cfg_half_rate = rf[5'h1F];

  // R3
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_r |-> busy);

  // R3
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_r) |-> $past(cnt) == 5'd15);

  // R7
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(devad));

  // R6
  lh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lh_tx) || $fell(lh_rx)) |-> $past(clr8));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_idle) |-> $past(wr_rf));

  // R10
  addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inc_go) |-> addr45 == $past(addr45) + 16'd1);
endmodule

// File: tb/mgmt_serial_regs_test.sv
module mgmt_serial_regs_test;
  logic clk = 0, rst_n = 0, mdc = 0, mdio_m = 1;
  logic [1:0] strap = 2'b11;
  logic [3:0] lane_ok = 4'hF;
  logic tx_fault = 0, rx_fault = 0;
  logic mdio_o, mdio_oe;
  logic [15:0] c_ctl, c_m1, c_m2, c_err, c_rxc, c_sym, c_idle, c_test, c_half;
  int tests = 0, fails = 0;
  logic [15:0] mdl [32];
  logic lh_t = 0, lh_r = 0;
  localparam logic [31:0] WRM = 32'hCB43_0001;

  always #5 clk = ~clk;

  mgmt_serial_regs uut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .mdc(mdc), .mdio_i(mdio_m),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .lane_ok(lane_ok),
    .tx_fault(tx_fault), .rx_fault(rx_fault),
    .cfg_control(c_ctl), .cfg_misc1(c_m1), .cfg_misc2(c_m2),
    .cfg_err_code(c_err), .cfg_rx_clk(c_rxc), .cfg_symbol(c_sym),
    .cfg_idle(c_idle), .cfg_test(c_test), .cfg_half_rate(c_half));

  initial begin
    repeat (190000) @(negedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input int i);
    case (i)
      'h00: return 16'h2040; 'h10: return 16'h00C0; 'h11: return 16'h0140;
      'h16: return 16'h00FF; 'h18: return 16'h0001; 'h19: return 16'h000F;
      'h1B: return 16'h0007; 'h1E: return 16'hAAAA; default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] expv(input int i);
    case (i)
      1: return {1'b1, 11'b0, lane_ok};
      4: return 16'h0001;
      5: return 16'h0021;
      8: return {1'b1, 3'b0, lh_t, lh_r, 10'b0};
      default: return WRM[i] ? mdl[i] : 16'h0000;
    endcase
  endfunction

  function automatic logic [4:0] dev_of(input logic [1:0] s);
    case (s)
      2'b11: return 5'd5; 2'b10: return 5'd4; 2'b01: return 5'd30; default: return 5'd31;
    endcase
  endfunction

  task automatic do_reset(input logic [1:0] s);
    strap = s;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) mdl[i] = dflt(i);
    lh_t = 0; lh_r = 0;
  endtask

  task automatic bitcyc(input logic b, output logic o, output logic e);
    mdc = 0; mdio_m = b;
    repeat (4) @(negedge clk);
    o = mdio_o; e = mdio_oe;
    mdc = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic st1, input logic [1:0] op, input logic [4:0] pa,
                       input logic [4:0] ra, input logic [15:0] wd, input logic rdm,
                       output logic [15:0] rd, output int good, output int bad);
    logic [31:0] fb;
    logic o, e;
    fb = {1'b0, st1, op, pa, ra, (rdm ? 2'b11 : 2'b10), (rdm ? 16'hFFFF : wd)};
    rd = 0; good = 0; bad = 0;
    for (int i = 0; i < 32; i++) begin
      bitcyc(1'b1, o, e);
      if (e) bad++;
    end
    for (int i = 0; i < 32; i++) begin
      bitcyc(fb[31-i], o, e);
      if (e) begin
        if (i >= 16) good++; else bad++;
      end
      if (i >= 16) rd = {rd[14:0], o};
    end
    bitcyc(1'b1, o, e);
    if (e) bad++;
  endtask

  task automatic rd22(input logic [4:0] ra, input logic [4:0] pa, input logic ans,
                      output logic [15:0] d);
    int g, b;
    frame(1'b1, 2'b10, pa, ra, 16'h0, 1'b1, d, g, b);
    chk("R3 oe window", 16'(g + 100 * b), ans ? 16'd16 : 16'd0);
  endtask

  task automatic wr22(input logic [4:0] ra, input logic [4:0] pa, input logic [15:0] d);
    logic [15:0] x; int g, b;
    frame(1'b1, 2'b01, pa, ra, d, 1'b0, x, g, b);
    chk("R3 no drive on write", 16'(g + b), 16'd0);
  endtask

  task automatic c45(input logic [1:0] op, input logic [4:0] dv, input logic [15:0] d,
                     input logic ans, output logic [15:0] r);
    int g, b;
    logic rdm;
    rdm = op[1];
    frame(1'b0, op, 5'd0, dv, d, rdm, r, g, b);
    chk("R8 oe window", 16'(g + 100 * b), (rdm && ans) ? 16'd16 : 16'd0);
  endtask

  initial begin
    logic [15:0] d, p;
    do_reset(2'b11);
    // R1 reset defaults on cfg ports
    chk("R1 control", c_ctl, 16'h2040);
    chk("R1 misc1", c_m1, 16'h00C0);
    chk("R1 misc2", c_m2, 16'h0140);
    chk("R1 err", c_err, 16'h00FF);
    chk("R1 rxclk", c_rxc, 16'h0001);
    chk("R1 symbol", c_sym, 16'h000F);
    chk("R1 idle", c_idle, 16'h0007);
    chk("R1 test", c_test, 16'hAAAA);
    chk("R1 half", c_half, 16'h0000);
    // R1 R4 R5 read sweep of defaults
    for (int a = 0; a < 32; a++) begin
      rd22(5'(a), 5'd0, 1'b1, d);
      chk(WRM[a] ? "R1 read default" : "R4 R5 read fixed", d, expv(a));
    end
    // R2 R4 R5 write sweep then read back
    for (int a = 0; a < 32; a++) begin
      p = 16'(a * 16'h0111) ^ 16'hC3A5;
      wr22(5'(a), 5'd0, p);
      if (WRM[a]) mdl[a] = p;
    end
    for (int a = 0; a < 32; a++) begin
      rd22(5'(a), 5'd0, 1'b1, d);
      chk(WRM[a] ? "R2 write readback" : "R4 R5 write ignored", d, expv(a));
    end
    chk("R2 cfg_idle port", c_idle, mdl[5'h1B]);
    chk("R2 cfg_half port", c_half, mdl[5'h1F]);
    // R2 R3 wrong port address
    rd22(5'h1B, 5'd1, 1'b0, d);
    wr22(5'h1B, 5'd3, 16'h5555);
    chk("R2 wrong port write", c_idle, mdl[5'h1B]);
    lane_ok = 4'h5;
    rd22(5'h01, 5'd0, 1'b1, d);
    chk("R4 status lanes", d, 16'h8005);
    lane_ok = 4'hF;
    // R6 latched-high faults
    tx_fault = 1; repeat (5) @(negedge clk); tx_fault = 0;
    rd22(5'h08, 5'd0, 1'b1, d);
    chk("R6 tx latched", d, 16'h8800);
    rd22(5'h08, 5'd0, 1'b1, d);
    chk("R6 tx cleared", d, 16'h8000);
    rx_fault = 1; repeat (3) @(negedge clk);
    rd22(5'h08, 5'd0, 1'b1, d);
    chk("R6 rx live", d, 16'h8400);
    rx_fault = 0;
    rd22(5'h08, 5'd0, 1'b1, d);
    chk("R6 rx held after read", d, 16'h8400);
    rd22(5'h08, 5'd0, 1'b1, d);
    chk("R6 rx cleared", d, 16'h8000);
    // R7 R8 R9 strap sweep
    for (int s = 0; s < 4; s++) begin
      logic [4:0] dv;
      do_reset(2'(s));
      dv = dev_of(2'(s));
      strap = ~strap;
      for (int c = 0; c < 4; c++) begin
        logic [4:0] cand;
        cand = dev_of(2'(c));
        c45(2'b00, cand, 16'h0008, cand == dv, d);
        c45(2'b11, cand, 16'h0, cand == dv, d);
        if (cand == dv) chk("R7 R9 fault word by devad", d, 16'h8000);
      end
    end
    // R9 vendor window write, seen on both formats
    c45(2'b00, 5'd5, 16'hC00B, 1'b1, d);
    c45(2'b01, 5'd5, 16'h1234, 1'b1, d);
    mdl[5'h1B] = 16'h1234;
    chk("R9 vendor write port", c_idle, 16'h1234);
    rd22(5'h1B, 5'd0, 1'b1, d);
    chk("R9 vendor write short read", d, 16'h1234);
    // R10 read-increment over the vendor window
    c45(2'b00, 5'd5, 16'hC000, 1'b1, d);
    for (int n = 0; n < 16; n++) begin
      c45(2'b10, 5'd5, 16'h0, 1'b1, d);
      chk("R10 R9 incrementing read", d, expv(16 + n));
    end
    c45(2'b11, 5'd5, 16'h0, 1'b1, d);
    chk("R5 R10 past window reads 0", d, 16'h0000);
    c45(2'b00, 5'd5, 16'h0000, 1'b1, d);
    c45(2'b11, 5'd5, 16'h0, 1'b1, d);
    chk("R10 plain read 1", d, 16'h2040);
    c45(2'b11, 5'd5, 16'h0, 1'b1, d);
    chk("R10 plain read no inc", d, 16'h2040);
    c45(2'b00, 5'd5, 16'h0004, 1'b1, d);
    c45(2'b01, 5'd5, 16'hFFFF, 1'b1, d);
    c45(2'b11, 5'd5, 16'h0, 1'b1, d);
    chk("R4 R9 extended RO write ignored", d, 16'h0001);
    c45(2'b00, 5'd5, 16'h2000, 1'b1, d);
    c45(2'b01, 5'd5, 16'h7777, 1'b1, d);
    c45(2'b11, 5'd5, 16'h0, 1'b1, d);
    chk("R5 R9 unimplemented extended", d, 16'h0000);
    c45(2'b00, 5'd4, 16'h0010, 1'b0, d);
    c45(2'b01, 5'd4, 16'h9999, 1'b0, d);
    chk("R8 wrong devad write ignored", c_misc_or(c_m1), mdl[5'h10]);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [15:0] c_misc_or(input logic [15:0] v);
    return v;
  endfunction
endmodule